// File: doc/BRIEF.md
# Multi-drop bus node frame filter

This block sits behind a frame decoder on a shared serial bus. Each time the decoder completes a frame it presents one event: the decoded payload length and the first four payload bytes. From the length alone the block decides what kind of frame arrived. It then decides whether this node is being spoken to and raises single-cycle strobes that ask other logic to act.

Those strobes cover three requests: send the node identity, send a status reply, and take a half-framebuffer that has just arrived. The block also keeps a saturating count of frames it judged invalid, and it pulses error and activity indicators.

A node becomes addressed only when an address frame carries its own 32-bit identity. It then accepts exactly one following frame and falls back to ignoring. Discovery requests are answered only during a short window after reset, measured in system tick pulses.

Top module: `bus_node_filter`

## Requirements
- R1: After reset the node is not addressed, the invalid count is zero and every strobe and indicator output is low.
- R2: Every frame event produces `comm_pulse` high for exactly the next cycle. At most one of `reply_id`, `reply_status`, `fb_accept` and `err_pulse` is high in any cycle.
- R3: A 4-byte frame compares `frm_head` with `NODE_ID`. The compare is little-endian: payload byte 0 sits in bits 7:0 and byte 3 in bits 31:24. A match sets the addressed state; a mismatch clears it. The frame is not counted as invalid.
- R4: A 0-byte frame raises `reply_id` only if fewer than `DISC_TICKS` pulses of `tick` occurred in the cycles before the frame's cycle. A tick in the same cycle as the frame is not yet counted. A discovery frame leaves the addressed state unchanged.
- R5: A 1-byte frame whose byte 0 (bits 7:0) is 0x01, received while addressed, raises `reply_status`. The state returns to not addressed.
- R6: A 1-byte frame with any other byte value, received while addressed, raises no strobe and does not change the invalid count. The state returns to not addressed.
- R7: A 1-byte frame received while not addressed increments the invalid count and raises `err_pulse`.
- R8: A frame of `FB_LEN` bytes (default 16) received while addressed raises `fb_accept` and returns to not addressed. Received while not addressed, it raises nothing and is not counted.
- R9: A frame of any length other than 0, 1, 4 or `FB_LEN` increments the invalid count, raises `err_pulse` and clears the addressed state.
- R10: The invalid count saturates at all ones instead of wrapping.
- R11: All outputs are registered: the response to a frame event appears in the cycle after it, and strobes are low in a cycle that follows no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | System tick pulse that times the discovery window |
| frm_valid | input | 1 | One-cycle frame-complete event |
| frm_len | input | LEN_W | Decoded payload length |
| frm_head | input | 32 | Payload bytes 0..3, byte 0 in bits 7:0 |
| addressed | output | 1 | Node currently addressed |
| reply_id | output | 1 | Request to send the node identity |
| reply_status | output | 1 | Request to send a status reply |
| fb_accept | output | 1 | Half-framebuffer frame accepted |
| err_pulse | output | 1 | Invalid frame seen |
| comm_pulse | output | 1 | Frame activity seen |
| invalid_cnt | output | CNT_W | Saturating invalid-frame count |

## Verification
The tick counter and the frame decision can fall in the same cycle. The bench drives ticks until 99 have been counted. It then issues a discovery frame together with the hundredth tick and expects `reply_id`, because that tick is not yet counted. The next discovery frame must get no reply. The count saturation also meets an error frame in the same cycle: the bench builds the design with a narrow count and keeps sending bad lengths past all ones. It expects `err_pulse` on each of those frames while the count stays pinned.

// File: rtl/bus_node_filter.sv
module bus_node_filter #(
  parameter int          LEN_W      = 8,
  parameter logic [31:0] NODE_ID    = 32'hA5C3_0F71,
  parameter int          DISC_TICKS = 100,
  parameter int          CNT_W      = 32,
  parameter int          FB_LEN     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             frm_valid,
  input  logic [LEN_W-1:0] frm_len,
  input  logic [31:0]      frm_head,
  output logic             addressed,
  output logic             reply_id,
  output logic             reply_status,
  output logic             fb_accept,
  output logic             err_pulse,
  output logic             comm_pulse,
  output logic [CNT_W-1:0] invalid_cnt
);

  localparam int TW = $clog2(DISC_TICKS + 1);
  localparam logic [TW-1:0]    TICK_LIM = TW'(DISC_TICKS);
  localparam logic [LEN_W-1:0] L_DISC = '0;
  localparam logic [LEN_W-1:0] L_CMD  = LEN_W'(1);
  localparam logic [LEN_W-1:0] L_ADDR = LEN_W'(4);
  localparam logic [LEN_W-1:0] L_FB   = LEN_W'(FB_LEN);

  logic [TW-1:0] tick_cnt;
  logic          disc_open, cnt_full;

  assign disc_open = tick_cnt < TICK_LIM;
  assign cnt_full  = &invalid_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) tick_cnt <= '0;
    else if (tick && disc_open) tick_cnt <= tick_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addressed    <= 1'b0;
      reply_id     <= 1'b0;
      reply_status <= 1'b0;
      fb_accept    <= 1'b0;
      err_pulse    <= 1'b0;
      comm_pulse   <= 1'b0;
      invalid_cnt  <= '0;
    end else begin
      reply_id     <= 1'b0;
      reply_status <= 1'b0;
      fb_accept    <= 1'b0;
      err_pulse    <= 1'b0;
      comm_pulse   <= frm_valid;
      if (frm_valid) begin
        if (frm_len == L_DISC) begin
          reply_id <= disc_open;
        end else if (frm_len == L_ADDR) begin
          addressed <= (frm_head == NODE_ID);
        end else if (frm_len == L_CMD) begin
          addressed <= 1'b0;
          if (addressed) begin
            reply_status <= (frm_head[7:0] == 8'h01);
          end else begin
            err_pulse <= 1'b1;
            if (!cnt_full) invalid_cnt <= invalid_cnt + 1'b1;
          end
        end else if (frm_len == L_FB) begin
          fb_accept <= addressed;
          addressed <= 1'b0;
        end else begin
          addressed <= 1'b0;
          err_pulse <= 1'b1;
          if (!cnt_full) invalid_cnt <= invalid_cnt + 1'b1;
        end
      end
    end
  end

  // R2: strobes are mutually exclusive and each implies activity
  p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reply_id, reply_status, fb_accept, err_pulse}));
  p_comm_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reply_id || reply_status || fb_accept || err_pulse) |-> comm_pulse);
  p_status_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reply_status |-> (!addressed && $past(addressed)));
  p_fb_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fb_accept |-> (!addressed && $past(addressed)));
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_full |=> &invalid_cnt);
  p_err_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(invalid_cnt) |-> err_pulse);
  p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_valid |=> !comm_pulse);

endmodule

// File: tb/bus_node_filter_tb.sv
module bus_node_filter_tb;
  localparam int          CW  = 4;
  localparam logic [31:0] NID = 32'hA5C3_0F71;

  logic clk = 0, rst_n = 0, tick = 0, frm_valid = 0;
  logic [7:0]  frm_len = '0;
  logic [31:0] frm_head = '0;
  logic addressed, reply_id, reply_status, fb_accept, err_pulse, comm_pulse;
  logic [CW-1:0] invalid_cnt;

  always #4 clk = ~clk;

  bus_node_filter #(.LEN_W(8), .NODE_ID(NID), .DISC_TICKS(100), .CNT_W(CW), .FB_LEN(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .frm_valid(frm_valid), .frm_len(frm_len),
    .frm_head(frm_head), .addressed(addressed), .reply_id(reply_id),
    .reply_status(reply_status), .fb_accept(fb_accept), .err_pulse(err_pulse),
    .comm_pulse(comm_pulse), .invalid_cnt(invalid_cnt));

  typedef struct packed {
    logic a, rid, rs, fb, err;
    logic [CW-1:0] cnt;
  } exp_t;

  exp_t q[$];
  string tagq[$];
  int total = 0, bad = 0, ticks = 0;
  logic m_addr = 0;
  logic [CW-1:0] m_cnt = '0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pulse_ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1; ticks++;
      @(negedge clk); tick = 0;
    end
  endtask

  task automatic bump();
    if (m_cnt != '1) m_cnt++;
  endtask

  task automatic send(string tag, logic [7:0] len, logic [31:0] head, bit with_tick);
    exp_t e;
    e = '0;
    if (len == 0) e.rid = (ticks < 100);
    else if (len == 4) m_addr = (head == NID);
    else if (len == 1) begin
      if (m_addr) e.rs = (head[7:0] == 8'h01);
      else begin e.err = 1; bump(); end
      m_addr = 0;
    end else if (len == 16) begin
      e.fb = m_addr; m_addr = 0;
    end else begin
      e.err = 1; bump(); m_addr = 0;
    end
    e.a = m_addr; e.cnt = m_cnt;
    q.push_back(e); tagq.push_back(tag);
    @(negedge clk);
    frm_valid = 1; frm_len = len; frm_head = head; tick = with_tick;
    @(negedge clk);
    frm_valid = 0; tick = 0;
    if (with_tick) ticks++;
    @(negedge clk);
    check({tag, " R11 quiet after event"},
          {28'd0, comm_pulse, reply_id, reply_status, fb_accept}, 32'd0);
  endtask

  initial begin : monitor
    exp_t e;
    string t;
    forever begin
      @(posedge clk);
      if (frm_valid) begin
        @(negedge clk);
        e = q.pop_front(); t = tagq.pop_front();
        check({t, " R2 comm"}, {31'd0, comm_pulse}, 32'd1);
        check(t, {23'd0, addressed, reply_id, reply_status, fb_accept, err_pulse, invalid_cnt},
              {23'd0, e});
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset state", {24'd0, addressed, reply_id, reply_status, fb_accept, err_pulse, comm_pulse, invalid_cnt[1:0]}, 32'd0);
    check("R1 reset count", {28'd0, invalid_cnt}, 32'd0);
    send("R4 discovery early", 8'd0, 32'd0, 0);
    send("R3 address mismatch", 8'd4, 32'h1234_5678, 0);
    send("R7 cmd while ignoring", 8'd1, 32'h1, 0);
    send("R3 address match", 8'd4, NID, 0);
    send("R5 status command", 8'd1, 32'h1, 0);
    send("R3 rematch", 8'd4, NID, 0);
    send("R6 other command", 8'd1, 32'h7, 0);
    send("R6 after other cmd", 8'd1, 32'h1, 0);
    send("R3 match for fb", 8'd4, NID, 0);
    send("R8 fb accepted", 8'd16, 32'h0, 0);
    send("R8 fb ignored", 8'd16, 32'h0, 0);
    send("R3 match for bad len", 8'd4, NID, 0);
    send("R9 bad length", 8'd5, 32'h0, 0);
    send("R3 byte-swapped id", 8'd4, 32'h710F_C3A5, 0);
    send("R3 match before disc", 8'd4, NID, 0);
    send("R4 disc keeps state", 8'd0, 32'h0, 0);
    send("R5 status after disc", 8'd1, 32'h1, 0);
    pulse_ticks(99);
    send("R4 disc with same-cycle tick", 8'd0, 32'h0, 1);
    send("R4 disc window closed", 8'd0, 32'h0, 0);
    for (int i = 0; i < 14; i++) send("R10 saturate", 8'd9, 32'h0, 0);
    send("R10 pinned at max", 8'd200, 32'h0, 0);
    send("R9 len 2", 8'd2, 32'h0, 0);
    repeat (2) @(negedge clk);
    check("R11 queue drained", q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule